// File: doc/BRIEF.md
# Four-Channel Scaled-Counter PWM Timer

This block is a register-mapped timer for pulse-width and periodic-interrupt generation. A 31-bit up-counter runs while either of two run enables is set. A 4-bit shift amount picks a 16-bit window of the counter, called the scaled count. That window is compared with four 16-bit compare values, one per channel. When the scaled count reaches or passes a channel's compare value, the channel raises a sticky pending flag. The flag drives that channel's interrupt line. A registered copy of the raw match level is also brought out as the channel's PWM waveform.

There are two run modes, continuous and one-shot. The one-shot enable is cleared by hardware when the counter carries out of its top bit. If zero-compare is enabled, a match on channel 0 returns the counter to zero and also cancels one-shot. Software reaches the configuration, count, scaled-count and compare registers through a simple single-cycle port: a write strobe, an address and write data, with read data returned combinationally. The configuration word also holds stored bits that have no effect on the block.

Top module: `pwm_timer`

## Requirements
- R1: The counter is 31 bits wide and wraps from 0x7FFFFFFF to 0. Reads of the count register (offset 0x08) return the counter in bits 30:0, and bit 31 always reads 0.
- R2: The scaled-count register (offset 0x10) reads as bits 15:0 of (counter >> scale), with bits 31:16 zero. The scale is configuration bits 3:0.
- R3: The counter adds one per clock while configuration bit 12 (continuous run) or bit 13 (one-shot run) is set. With both bits clear it holds its value.
- R4: Each compare register (offsets 0x20, 0x24, 0x28, 0x2C for channels 0 to 3) keeps only bits 15:0 of a write. It reads back with bits 31:16 zero.
- R5: Channel i's pending flag is configuration bit 28+i. It sets on the clock edge after a cycle in which scaled count >= compare i, and then stays set. irq_o[i] equals that flag.
- R6: When configuration bit 9 (zero-compare) is set and channel 0 matches, the counter becomes 0 on the next edge and bit 13 is cleared.
- R7: A carry out of the counter while it is counting clears configuration bit 13 on the same edge on which the counter wraps to 0.
- R8: A write to offset 0x08 loads bits 30:0 of the write data into the counter. A write to offset 0x10 loads (data[15:0] << scale) truncated to 31 bits, using the scale in force before the write. A register load takes priority over a zero-compare clear, and a zero-compare clear takes priority over the increment.
- R9: The compare check also runs while counting is stopped. A count or scaled-count write that brings scaled count >= compare i sets pending flag i one edge later.
- R10: Reads of any offset other than 0x00, 0x08, 0x10 and 0x20 to 0x2C return 0. Writes to such offsets change nothing. Configuration bits 27:0 read back as written.
- R11: Reset (synchronous, active high) sets the configuration, all compare registers and the counter to 0. The interrupt and PWM outputs are low while reset is held.
- R12: A configuration write loads the pending flags from data bits 31:28, so writing 0 clears a flag and writing 1 sets it. A write in the same cycle as a match takes priority over the match. A write in the same cycle as a carry or zero-compare clear also takes priority for bit 13.
- R13: pwm_o[i] is high in the cycle after one in which scaled count >= compare i, and low in the cycle after one in which it is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 4 | Per-channel interrupt, equal to the pending flags |
| pwm_o | output | 4 | Per-channel registered match level |

## Verification
The hardest event to reach from the ports is the carry out of the 31-bit counter, which would take about two billion cycles of free counting. The bench loads the count register with values at or just below 0x7FFFFFFF and then enables one-shot mode, so the carry, the wrap and the one-shot cancel happen within a few cycles. Zero-compare at a large scale is hard to reach for the same reason. The random stimulus keeps the compare values small and the scale mostly low, and often loads the counter near the top of its range. A cycle-level reference model in the bench follows every write, match, clear and wrap, and each cycle's outputs are compared with it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CNT_W    = 31;
    localparam int CMP_W    = 16;
    localparam int SCALE_W  = 4;
    localparam int NCHAN    = 4;
    localparam int CH_W     = $clog2(NCHAN);
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    // configuration bit positions that the logic decodes
    localparam int ZERO_BIT    = 9;
    localparam int RUN_BIT     = 12;
    localparam int ONESHOT_BIT = 13;
    localparam int PEND_LSB    = 28;
    localparam int CFG_LO_W    = PEND_LSB;

    localparam logic [ADDR_W-1:0] OFS_CFG = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SCL = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CMP = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_CNT,
        SEL_SCL,
        SEL_CMP
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e        sel;
        logic [CH_W-1:0] chan;
    } reg_dec_t;

    // shared per-cycle controls of the count register
    typedef struct packed {
        logic             load;
        logic [CNT_W-1:0] load_val;
        logic             clr;
        logic             inc;
    } cnt_ctl_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.sel  = SEL_NONE;
        d.chan = '0;
        if (a == OFS_CFG)      d.sel = SEL_CFG;
        else if (a == OFS_CNT) d.sel = SEL_CNT;
        else if (a == OFS_SCL) d.sel = SEL_SCL;
        else begin
            for (int i = 0; i < NCHAN; i++) begin
                if (a == ADDR_W'(int'(OFS_CMP) + 4 * i)) begin
                    d.sel  = SEL_CMP;
                    d.chan = CH_W'(i);
                end
            end
        end
        return d;
    endfunction

    function automatic logic [CMP_W-1:0] scaled_window(input logic [CNT_W-1:0] c,
                                                       input logic [SCALE_W-1:0] s);
        return CMP_W'(c >> s);
    endfunction

    function automatic logic [CNT_W-1:0] scaled_to_count(input logic [CMP_W-1:0] v,
                                                         input logic [SCALE_W-1:0] s);
        return CNT_W'(CNT_W'(v) << s);
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    output logic [CNT_W-1:0] cnt_q,
    output logic             carry
);

    // carry only when the increment is the action actually taken
    assign carry = ctl.inc && !ctl.load && !ctl.clr && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl.load) begin
            cnt_q <= ctl.load_val;
        end else if (ctl.clr) begin
            cnt_q <= '0;
        end else if (ctl.inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
    import pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CFG_LO_W-1:0] wdata,
    input  logic                hw_stop,
    output logic [CFG_LO_W-1:0] cfg_q
);

    logic [CFG_LO_W-1:0] cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = wdata;
        end else if (hw_stop) begin
            cfg_d[ONESHOT_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CMP_W-1:0] scaled,
    input  logic             cmp_wr,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic             pend_wr,
    input  logic             pend_wdata,
    output logic [CMP_W-1:0] cmp_q,
    output logic             match,
    output logic             pend_q,
    output logic             pwm_q
);

    assign match = (scaled >= cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            pend_q <= 1'b0;
            pwm_q  <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= cmp_wdata;
            pend_q <= pend_wr ? pend_wdata : (pend_q | match);
            pwm_q  <= match;
        end
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCHAN-1:0]  irq_o,
    output logic [NCHAN-1:0]  pwm_o
);

    reg_dec_t            dec;
    logic                cfg_wr;
    logic                cnt_wr;
    logic                scl_wr;
    logic [CFG_LO_W-1:0] cfg_q;
    logic [SCALE_W-1:0]  scale;
    logic                run_en;
    logic                oneshot;
    logic [CNT_W-1:0]    cnt_q;
    logic                carry;
    logic                zclr;
    logic                cnt_load;
    cnt_ctl_t            cnt_ctl;
    logic [CMP_W-1:0]    scaled;
    logic [CMP_W-1:0]    cmp_q [NCHAN];
    logic [NCHAN-1:0]    match_v;
    logic [NCHAN-1:0]    pend_v;
    logic [NCHAN-1:0]    pwm_v;

    assign dec    = decode_addr(reg_addr);
    assign cfg_wr = reg_wr && (dec.sel == SEL_CFG);
    assign cnt_wr = reg_wr && (dec.sel == SEL_CNT);
    assign scl_wr = reg_wr && (dec.sel == SEL_SCL);

    assign scale   = cfg_q[SCALE_W-1:0];
    assign oneshot = cfg_q[ONESHOT_BIT];
    assign run_en  = cfg_q[RUN_BIT] | oneshot;
    assign scaled  = scaled_window(cnt_q, scale);
    assign zclr    = cfg_q[ZERO_BIT] & match_v[0];

    assign cnt_load         = cnt_wr | scl_wr;
    assign cnt_ctl.load     = cnt_load;
    assign cnt_ctl.load_val = cnt_wr ? reg_wdata[CNT_W-1:0]
                                     : scaled_to_count(reg_wdata[CMP_W-1:0], scale);
    assign cnt_ctl.clr      = zclr;
    assign cnt_ctl.inc      = run_en;

    pwm_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .ctl   (cnt_ctl),
        .cnt_q (cnt_q),
        .carry (carry)
    );

    pwm_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wdata   (reg_wdata[CFG_LO_W-1:0]),
        .hw_stop (zclr | carry),
        .cfg_q   (cfg_q)
    );

    for (genvar i = 0; i < NCHAN; i++) begin : g_ch
        logic cmp_sel;
        assign cmp_sel = reg_wr && (dec.sel == SEL_CMP) && (dec.chan == CH_W'(i));

        pwm_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .scaled     (scaled),
            .cmp_wr     (cmp_sel),
            .cmp_wdata  (reg_wdata[CMP_W-1:0]),
            .pend_wr    (cfg_wr),
            .pend_wdata (reg_wdata[PEND_LSB+i]),
            .cmp_q      (cmp_q[i]),
            .match      (match_v[i]),
            .pend_q     (pend_v[i]),
            .pwm_q      (pwm_v[i])
        );
    end

    assign irq_o = pend_v;
    assign pwm_o = pwm_v;

    always_comb begin
        unique case (dec.sel)
            SEL_CFG: reg_rdata = {pend_v, cfg_q};
            SEL_CNT: reg_rdata = DATA_W'(cnt_q);
            SEL_SCL: reg_rdata = DATA_W'(scaled);
            SEL_CMP: reg_rdata = DATA_W'(cmp_q[dec.chan]);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NCHAN-1:0]  pwm_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              cnt_load,
    input logic              run_en,
    input logic              zclr,
    input logic              carry,
    input logic              oneshot,
    input logic              cfg_wr,
    input logic [NCHAN-1:0]  match_v,
    input logic [NCHAN-1:0]  pend_v
);

    // R1: top bit of the count read is always zero
    assert_cnt_msb_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_CNT) |-> (reg_rdata[DATA_W-1] == 1'b0));

    // R3: stopped counter holds
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !cnt_load && !zclr) |=> $stable(cnt_q));

    // R3: running counter advances by one
    assert_step_running_R3: assert property (@(posedge clk) disable iff (rst)
        (run_en && !cnt_load && !zclr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

    // R6: zero-compare returns the counter to zero
    assert_zero_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (zclr && !cnt_load) |=> (cnt_q == '0));

    // R7: carry out cancels one-shot
    assert_carry_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (carry && !cfg_wr) |=> !oneshot);

    // R12: configuration write loads the pending flags
    assert_pend_load_R12: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (pend_v == $past(reg_wdata[DATA_W-1:PEND_LSB])));

    for (genvar i = 0; i < NCHAN; i++) begin : g_chk
        // R5: a match sets the pending flag one edge later
        assert_pend_set_R5: assert property (@(posedge clk) disable iff (rst)
            (match_v[i] && !cfg_wr) |=> pend_v[i]);

        // R13: PWM output is the match level delayed one cycle
        assert_pwm_level_R13: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (pwm_o[i] == $past(match_v[i])));
    end

    // R4: compare reads carry no upper bits
    assert_cmp_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[ADDR_W-1:4] == OFS_CMP[ADDR_W-1:4] && !reg_wr) |-> (reg_rdata[DATA_W-1:CMP_W] == '0));

endmodule

bind pwm_timer pwm_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_o     (pwm_o),
    .cnt_q     (cnt_q),
    .cnt_load  (cnt_load),
    .run_en    (run_en),
    .zclr      (zclr),
    .carry     (carry),
    .oneshot   (oneshot),
    .cfg_wr    (cfg_wr),
    .match_v   (match_v),
    .pend_v    (pend_v)
);

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_o;
    logic [3:0]  pwm_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_cfg;
    logic [30:0] m_cnt;
    logic [15:0] m_cmp [4];
    logic [3:0]  m_pwm;

    always #10 clk = ~clk;

    pwm_timer dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .pwm_o     (pwm_o)
    );

    function automatic logic [15:0] exp_scaled(input logic [30:0] c, input logic [3:0] s);
        logic [30:0] t;
        t = c >> s;
        return t[15:0];
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_cfg;
            8'h08: return {1'b0, m_cnt};
            8'h10: return {16'h0, exp_scaled(m_cnt, m_cfg[3:0])};
            8'h20: return {16'h0, m_cmp[0]};
            8'h24: return {16'h0, m_cmp[1]};
            8'h28: return {16'h0, m_cmp[2]};
            8'h2C: return {16'h0, m_cmp[3]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R5/R12 config";
            8'h08: return "R1/R3/R8 count";
            8'h10: return "R2 scaled";
            8'h20, 8'h24, 8'h28, 8'h2C: return "R4 compare";
            default: return "R10 unmapped";
        endcase
    endfunction

    task automatic model_step(input logic w, input logic [7:0] a, input logic [31:0] d);
        logic [3:0]  mt;
        logic [15:0] sc;
        logic        en, zc, ld, cy;
        logic [31:0] ncfg;
        logic [30:0] ncnt;
        sc = exp_scaled(m_cnt, m_cfg[3:0]);
        for (int i = 0; i < 4; i++) mt[i] = (sc >= m_cmp[i]);
        en = m_cfg[12] | m_cfg[13];
        zc = m_cfg[9] & mt[0];
        ld = w && (a == 8'h08 || a == 8'h10);
        cy = en && !ld && !zc && (m_cnt == 31'h7FFFFFFF);
        ncnt = m_cnt;
        if (w && a == 8'h08)      ncnt = d[30:0];
        else if (w && a == 8'h10) ncnt = 31'({15'h0, d[15:0]} << m_cfg[3:0]);
        else if (zc)              ncnt = 31'h0;
        else if (en)              ncnt = m_cnt + 31'd1;
        if (w && a == 8'h00) begin
            ncfg = d;
        end else begin
            ncfg = m_cfg;
            ncfg[31:28] = m_cfg[31:28] | mt;
            if (zc || cy) ncfg[13] = 1'b0;
        end
        for (int i = 0; i < 4; i++)
            if (w && a == 8'(8'h20 + 4 * i)) m_cmp[i] = d[15:0];
        m_cfg = ncfg;
        m_cnt = ncnt;
        m_pwm = mt;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, model at the rising edge, check at the next falling edge
    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] e;
        reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        model_step(w, a, d);
        @(negedge clk);
        reg_wr = 1'b0;
        chk(irq_o == m_cfg[31:28], "R5 irq", {28'h0, irq_o}, {28'h0, m_cfg[31:28]});
        chk(pwm_o == m_pwm, "R13 pwm", {28'h0, pwm_o}, {28'h0, m_pwm});
        e = model_read(a);
        chk(reg_rdata == e, tag_of(a), reg_rdata, e);
    endtask

    task automatic idle(input logic [7:0] a);
        cyc(1'b0, a, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cfg = '0; m_cnt = '0; m_pwm = '0;
        for (int i = 0; i < 4; i++) m_cmp[i] = '0;

        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        reg_addr = 8'h00; #1;
        chk(reg_rdata == 32'h0, "R11 reset config", reg_rdata, 32'h0);
        reg_addr = 8'h08; #1;
        chk(reg_rdata == 32'h0, "R11 reset count", reg_rdata, 32'h0);
        reg_addr = 8'h24; #1;
        chk(reg_rdata == 32'h0, "R11 reset compare", reg_rdata, 32'h0);
        chk(irq_o == 4'h0 && pwm_o == 4'h0, "R11 reset outputs", {24'h0, irq_o, pwm_o}, 32'h0);
        rst = 1'b0;

        // R4: upper bits of a compare write dropped
        cyc(1'b1, 8'h28, 32'hABCD_1234);
        idle(8'h28);
        chk(reg_rdata == 32'h0000_1234, "R4 compare truncation", reg_rdata, 32'h0000_1234);

        // R10: unmapped read and write
        cyc(1'b1, 8'h30, 32'hFFFF_FFFF);
        idle(8'h04);
        chk(reg_rdata == 32'h0, "R10 unmapped read", reg_rdata, 32'h0);

        // R8: scaled-count load at scale 4 and scale 15
        cyc(1'b1, 8'h00, 32'h0000_0004);
        cyc(1'b1, 8'h10, 32'h000F_1234);
        idle(8'h08);
        chk(reg_rdata == 32'h0001_2340, "R8 scaled load s4", reg_rdata, 32'h0001_2340);
        idle(8'h10);
        chk(reg_rdata == 32'h0000_1234, "R2 scaled read s4", reg_rdata, 32'h0000_1234);
        cyc(1'b1, 8'h00, 32'h0000_000F);
        cyc(1'b1, 8'h10, 32'h0000_FFFF);
        idle(8'h08);
        chk(reg_rdata == 32'h7FFF_8000, "R8 scaled load s15", reg_rdata, 32'h7FFF_8000);

        // R9: compare check while stopped
        cyc(1'b1, 8'h08, 32'h0);
        cyc(1'b1, 8'h24, 32'h0000_0010);
        cyc(1'b1, 8'h00, 32'h0);
        idle(8'h00);
        chk(irq_o[1] == 1'b0, "R9 channel 1 idle before load", {31'h0, irq_o[1]}, 32'h0);
        cyc(1'b1, 8'h08, 32'h0000_0010);
        chk(irq_o[1] == 1'b0, "R9 not yet pending", {31'h0, irq_o[1]}, 32'h0);
        idle(8'h00);
        chk(irq_o[1] == 1'b1, "R9 pending after stopped load", {31'h0, irq_o[1]}, 32'h1);

        // R7: carry out cancels one-shot
        cyc(1'b1, 8'h08, 32'h7FFF_FFFF);
        cyc(1'b1, 8'h00, 32'h0000_2000);
        idle(8'h00);
        chk(reg_rdata[13] == 1'b0, "R7 one-shot cleared on carry", {31'h0, reg_rdata[13]}, 32'h0);
        idle(8'h08);
        chk(reg_rdata == 32'h0, "R7 counter wrapped and stopped", reg_rdata, 32'h0);

        // R6: zero-compare on channel 0
        cyc(1'b1, 8'h20, 32'h0000_0003);
        cyc(1'b1, 8'h08, 32'h0);
        cyc(1'b1, 8'h00, 32'h0000_3200);
        idle(8'h08);
        idle(8'h08);
        idle(8'h08);
        idle(8'h08);
        chk(reg_rdata == 32'h0, "R6 counter cleared by channel 0", reg_rdata, 32'h0);
        idle(8'h00);
        chk(reg_rdata[13] == 1'b0 && reg_rdata[12] == 1'b1, "R6 one-shot cleared, run kept",
            {30'h0, reg_rdata[13:12]}, 32'h1);

        // R12: write 0 clears pending, write 1 stores it
        cyc(1'b1, 8'h20, 32'h0000_FFFF);
        cyc(1'b1, 8'h24, 32'h0000_FFFF);
        cyc(1'b1, 8'h28, 32'h0000_FFFF);
        cyc(1'b1, 8'h2C, 32'h0000_FFFF);
        cyc(1'b1, 8'h08, 32'h0);
        cyc(1'b1, 8'h00, 32'h5000_0000);
        chk(irq_o == 4'b0101, "R12 pending stored as written", {28'h0, irq_o}, 32'h5);

        // constrained random phase checked against the model
        for (int n = 0; n < 6000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          k;
            k = int'($urandom % 100);
            d = $urandom;
            case ($urandom % 8)
                0: a = 8'h00;
                1: a = 8'h08;
                2: a = 8'h10;
                3: a = 8'h20;
                4: a = 8'h24;
                5: a = 8'h28;
                6: a = 8'h2C;
                default: a = 8'(($urandom % 64) * 4);
            endcase
            if (k < 22) begin
                if (a == 8'h00) d[3:0] = ($urandom % 3 == 0) ? d[3:0] : 4'($urandom % 3);
                if (a == 8'h08 && ($urandom % 2 == 0)) d = 32'h7FFF_FFFF - ($urandom % 8);
                if (a >= 8'h20 && a <= 8'h2C) d[15:0] = 16'($urandom % 64);
                cyc(1'b1, a, d);
            end else begin
                idle(a);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule